// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a port of already synchronized input pins and turns their activity into interrupt requests. Software programs, separately for every pin, whether the pin is judged by its level or by its transitions, which polarity counts as active, and whether both transitions should count. Detected conditions appear in a raw status word. A per-pin enable word gates them into a masked status word, and the OR of the masked word drives one combined interrupt line toward the system interrupt controller.

Edge conditions are sticky. They stay recorded until software writes a one to the matching bit of the clear location. Level conditions are not stored: their status bit tracks the pin for as long as the pin is level-sensed. A simple single-cycle register port, a write strobe plus address and data with a combinational read data path, gives access to the configuration words and the two status words.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration word (level-select, both-edges, polarity, enable) reads 0, raw and masked status read 0 and `irq_o` is low; with these values all pins are edge-sensed on the falling edge and masked.
- R2: The configuration words sit at byte offsets 0x404 (level-select), 0x408 (both-edges), 0x40C (polarity) and 0x410 (enable). A write takes effect on the next clock edge. Bits at and above NPINS read 0, and unmapped offsets and the clear offset read 0.
- R3: With level-select bit = 1, raw status bit n equals 1 exactly when pin n equals polarity bit n (1 = active high, 0 = active low). It follows the pin with no latching.
- R4: With level-select = 0 and both-edges = 0, polarity bit 1 sets the sticky raw bit on a 0-to-1 pin change and polarity 0 sets it on a 1-to-0 change. The opposite change sets nothing. The bit is visible one clock after the new pin level is presented.
- R5: With level-select = 0 and both-edges = 1, either pin change sets the sticky raw bit, whatever the polarity bit holds.
- R6: Writing to offset 0x41C clears each edge status bit whose data bit is 1. Data bits of 0 leave their status untouched. A cleared level-sensed pin that is still active keeps reading 1.
- R7: When an edge on a pin and a clear of that pin's bit land in the same clock, the status bit ends up set.
- R8: Raw status reads at offset 0x414 and masked status at 0x418. Masked status equals raw status AND the enable word.
- R9: `irq_o` is high exactly when at least one masked status bit is 1.
- R10: Writes to the raw and masked status offsets change no configuration word and no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | Synchronized pin levels |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The in-RTL properties check on every cycle the edge-status rules. A recorded edge holds until a clear arrives. A clear empties the bit when no new change arrives, and a change together with a clear leaves it set. A single-polarity falling detector ignores rising changes. A level-sensed pin never keeps a stored edge. Writes to the status offsets leave the configuration untouched, and the interrupt line never rises while the enable word is zero. The exact mapping of each mode and polarity onto raw status, the readback layout, and the masked status and interrupt values come out only in the bench's sweep over every pin and every sensing mode.

// File: rtl/gid_pkg.sv
package gid_pkg;

   localparam int unsigned GID_OFF_LEVEL  = 32'h404;
   localparam int unsigned GID_OFF_DUAL   = 32'h408;
   localparam int unsigned GID_OFF_POL    = 32'h40C;
   localparam int unsigned GID_OFF_ENABLE = 32'h410;
   localparam int unsigned GID_OFF_RAW    = 32'h414;
   localparam int unsigned GID_OFF_MASKED = 32'h418;
   localparam int unsigned GID_OFF_CLEAR  = 32'h41C;

   localparam int unsigned GID_MIN_ADDR_W = 11;

   typedef enum logic [2:0] {
      GID_SEL_NONE,
      GID_SEL_LEVEL,
      GID_SEL_DUAL,
      GID_SEL_POL,
      GID_SEL_ENABLE,
      GID_SEL_RAW,
      GID_SEL_MASKED,
      GID_SEL_CLEAR
   } gid_sel_e;

endpackage

// File: rtl/gid_addr_dec.sv
module gid_addr_dec
   import gid_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output gid_sel_e          sel_o
);

   always_comb begin
      if (addr_i == ADDR_W'(GID_OFF_LEVEL))
         sel_o = GID_SEL_LEVEL;
      else if (addr_i == ADDR_W'(GID_OFF_DUAL))
         sel_o = GID_SEL_DUAL;
      else if (addr_i == ADDR_W'(GID_OFF_POL))
         sel_o = GID_SEL_POL;
      else if (addr_i == ADDR_W'(GID_OFF_ENABLE))
         sel_o = GID_SEL_ENABLE;
      else if (addr_i == ADDR_W'(GID_OFF_RAW))
         sel_o = GID_SEL_RAW;
      else if (addr_i == ADDR_W'(GID_OFF_MASKED))
         sel_o = GID_SEL_MASKED;
      else if (addr_i == ADDR_W'(GID_OFF_CLEAR))
         sel_o = GID_SEL_CLEAR;
      else
         sel_o = GID_SEL_NONE;
   end

endmodule

// File: rtl/gid_cfg_regs.sv
module gid_cfg_regs
   import gid_pkg::*;
#(
   parameter int unsigned NPINS    = 8,
   parameter bit          LEVEL_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  gid_sel_e         sel_i,
   input  logic [NPINS-1:0] wdata_i,
   output logic [NPINS-1:0] level_o,
   output logic [NPINS-1:0] dual_o,
   output logic [NPINS-1:0] pol_o,
   output logic [NPINS-1:0] enable_o,
   output logic [NPINS-1:0] clear_o
);

   logic [NPINS-1:0] dual_q;
   logic [NPINS-1:0] pol_q;
   logic [NPINS-1:0] enable_q;

   generate
      if (LEVEL_EN) begin : g_level_reg
         logic [NPINS-1:0] level_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               level_q <= '0;
            else if (wr_i && sel_i == GID_SEL_LEVEL)
               level_q <= wdata_i;
         end
         assign level_o = level_q;
      end else begin : g_level_none
         assign level_o = '0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dual_q   <= '0;
         pol_q    <= '0;
         enable_q <= '0;
      end else if (wr_i) begin
         if (sel_i == GID_SEL_DUAL)   dual_q   <= wdata_i;
         if (sel_i == GID_SEL_POL)    pol_q    <= wdata_i;
         if (sel_i == GID_SEL_ENABLE) enable_q <= wdata_i;
      end
   end

   assign dual_o   = dual_q;
   assign pol_o    = pol_q;
   assign enable_o = enable_q;
   assign clear_o  = (wr_i && sel_i == GID_SEL_CLEAR) ? wdata_i : '0;

   AST_STATUS_WRITE_NO_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && (sel_i == GID_SEL_RAW || sel_i == GID_SEL_MASKED))
      |=> $stable({level_o, dual_o, pol_o, enable_o})); // R10

endmodule

// File: rtl/gid_pin_det.sv
module gid_pin_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   input  logic level_mode_i,
   input  logic dual_i,
   input  logic pol_i,
   input  logic clear_i,
   output logic raw_o
);

   logic prev_q;
   logic edge_q;
   logic rise;
   logic fall;
   logic hit;

   assign rise = pin_i & ~prev_q;
   assign fall = ~pin_i & prev_q;
   assign hit  = ~level_mode_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         prev_q <= pin_i;
         if (level_mode_i)
            edge_q <= 1'b0;
         else
            edge_q <= hit | (edge_q & ~clear_i);
      end
   end

   assign raw_o = level_mode_i ? (pin_i == pol_i) : edge_q;

   AST_EDGE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && edge_q && !clear_i) |=> edge_q); // R6

   AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && clear_i && pin_i == prev_q) |=> !edge_q); // R6

   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && dual_i && pin_i != prev_q && clear_i) |=> edge_q); // R7

   AST_FALL_IGNORES_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_mode_i && !dual_i && !pol_i && pin_i && !prev_q && !edge_q) |=> !edge_q); // R4

   AST_LEVEL_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_mode_i && $past(level_mode_i)) |-> !edge_q); // R3

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gid_pkg::*;
#(
   parameter int unsigned NPINS    = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter bit          LEVEL_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPINS-1:0]  pin_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   generate
      if (NPINS < 1) begin : g_chk_npins
         $error("NPINS must be at least 1");
      end
      if (NPINS > DATA_W) begin : g_chk_width
         $error("NPINS must not exceed DATA_W");
      end
      if (ADDR_W < GID_MIN_ADDR_W) begin : g_chk_addr
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   gid_sel_e         sel;
   logic [NPINS-1:0] level_cfg;
   logic [NPINS-1:0] dual_cfg;
   logic [NPINS-1:0] pol_cfg;
   logic [NPINS-1:0] enable_cfg;
   logic [NPINS-1:0] clear_pulse;
   logic [NPINS-1:0] raw_stat;
   logic [NPINS-1:0] masked_stat;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata_i;

   gid_addr_dec #(
      .ADDR_W (ADDR_W)
   ) i_dec (
      .addr_i (bus_addr_i),
      .sel_o  (sel)
   );

   gid_cfg_regs #(
      .NPINS    (NPINS),
      .LEVEL_EN (LEVEL_EN)
   ) i_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (bus_wr_i),
      .sel_i    (sel),
      .wdata_i  (bus_wdata_i[NPINS-1:0]),
      .level_o  (level_cfg),
      .dual_o   (dual_cfg),
      .pol_o    (pol_cfg),
      .enable_o (enable_cfg),
      .clear_o  (clear_pulse)
   );

   generate
      for (genvar n = 0; n < NPINS; n++) begin : g_pin
         gid_pin_det i_det (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .pin_i        (pin_i[n]),
            .level_mode_i (level_cfg[n]),
            .dual_i       (dual_cfg[n]),
            .pol_i        (pol_cfg[n]),
            .clear_i      (clear_pulse[n]),
            .raw_o        (raw_stat[n])
         );
      end
   endgenerate

   assign masked_stat = raw_stat & enable_cfg;
   assign irq_o       = |masked_stat;

   always_comb begin
      case (sel)
         GID_SEL_LEVEL:  bus_rdata_o = DATA_W'(level_cfg);
         GID_SEL_DUAL:   bus_rdata_o = DATA_W'(dual_cfg);
         GID_SEL_POL:    bus_rdata_o = DATA_W'(pol_cfg);
         GID_SEL_ENABLE: bus_rdata_o = DATA_W'(enable_cfg);
         GID_SEL_RAW:    bus_rdata_o = DATA_W'(raw_stat);
         GID_SEL_MASKED: bus_rdata_o = DATA_W'(masked_stat);
         default:        bus_rdata_o = '0;
      endcase
   end

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (enable_cfg != '0)); // R9

endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

   localparam int NP = 8;
   localparam int AW = 12;
   localparam int DW = 32;

   localparam logic [AW-1:0] A_LEVEL  = 12'h404;
   localparam logic [AW-1:0] A_DUAL   = 12'h408;
   localparam logic [AW-1:0] A_POL    = 12'h40C;
   localparam logic [AW-1:0] A_ENABLE = 12'h410;
   localparam logic [AW-1:0] A_RAW    = 12'h414;
   localparam logic [AW-1:0] A_MASKED = 12'h418;
   localparam logic [AW-1:0] A_CLEAR  = 12'h41C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_detect #(
      .NPINS  (NP),
      .ADDR_W (AW),
      .DATA_W (DW)
   ) i_gpio_irq_detect (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .pin_i       (pins),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic chk_reg(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      addr = a;
      #1;
      check(tag, rdata, exp);
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      #1;
      check(tag, {31'd0, irq}, {31'd0, exp});
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pins = v;
      @(negedge clk);
   endtask

   task automatic chk_status(input string tag, input logic [NP-1:0] raw_exp, input logic [NP-1:0] en);
      logic [NP-1:0] m;
      m = raw_exp & en;
      chk_reg({tag, " R8 raw"}, A_RAW, DW'(raw_exp));
      chk_reg({tag, " R8 masked"}, A_MASKED, DW'(m));
      chk_irq({tag, " R9 irq"}, |m);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      chk_reg("R1 level", A_LEVEL, '0);
      chk_reg("R1 dual", A_DUAL, '0);
      chk_reg("R1 pol", A_POL, '0);
      chk_reg("R1 enable", A_ENABLE, '0);
      chk_reg("R1 raw", A_RAW, '0);
      chk_reg("R1 masked", A_MASKED, '0);
      chk_irq("R1 irq", 1'b0);

      // R2: width limiting and unmapped reads
      wr_reg(A_ENABLE, 32'hFFFF_FFFF);
      chk_reg("R2 enable upper bits", A_ENABLE, 32'h0000_00FF);
      chk_reg("R2 clear reads zero", A_CLEAR, '0);
      chk_reg("R2 unmapped", 12'h400, '0);
      wr_reg(A_ENABLE, '0);

      // Sweep: every pin, every sensing mode
      // mode 0 level-high, 1 level-low, 2 rising, 3 falling, 4 both
      for (int p = 0; p < NP; p++) begin
         for (int m = 0; m < 5; m++) begin
            logic lvl, pol, dual;
            logic [NP-1:0] bit_p, en, exp_hi, exp_lo;
            string tag;
            lvl   = (m < 2);
            pol   = (m == 0 || m == 2);
            dual  = (m == 4);
            bit_p = NP'(1) << p;
            en    = (((p + m) % 2) == 0) ? bit_p : '0;
            tag   = $sformatf("pin%0d mode%0d", p, m);
            wr_reg(A_LEVEL, lvl ? DW'(bit_p) : '0);
            wr_reg(A_DUAL, dual ? DW'(bit_p) : '0);
            wr_reg(A_POL, pol ? DW'(bit_p) : '0);
            wr_reg(A_ENABLE, DW'(en));
            wr_reg(A_CLEAR, 32'hFF);
            chk_reg({tag, " R2 pol readback"}, A_POL, pol ? DW'(bit_p) : '0);
            chk_reg({tag, " R2 level readback"}, A_LEVEL, lvl ? DW'(bit_p) : '0);

            exp_hi = (lvl ? pol : (dual | pol)) ? bit_p : '0;
            exp_lo = (lvl ? !pol : (dual | !pol)) ? bit_p : '0;

            set_pins(bit_p);
            chk_status({tag, lvl ? " R3 high" : (dual ? " R5 rise" : " R4 rise")}, exp_hi, en);
            if (lvl) begin
               wr_reg(A_CLEAR, DW'(bit_p));
               chk_status({tag, " R6 level clear no effect"}, exp_hi, en);
            end else begin
               wr_reg(A_CLEAR, DW'(~bit_p));
               chk_status({tag, " R6 zero bits keep"}, exp_hi, en);
               wr_reg(A_CLEAR, DW'(bit_p));
               chk_status({tag, " R6 cleared"}, '0, en);
            end
            set_pins('0);
            chk_status({tag, lvl ? " R3 low" : (dual ? " R5 fall" : " R4 fall")}, exp_lo, en);
            wr_reg(A_CLEAR, 32'hFF);
         end
      end

      // Multi-pin both-edge pattern
      wr_reg(A_LEVEL, '0);
      wr_reg(A_DUAL, 32'hFF);
      wr_reg(A_POL, 32'h00);
      wr_reg(A_ENABLE, 32'h0F);
      wr_reg(A_CLEAR, 32'hFF);
      set_pins(8'hA5);
      chk_status("R5 pattern A5", 8'hA5, 8'h0F);
      set_pins(8'h5A);
      chk_status("R5 pattern sticky", 8'hFF, 8'h0F);
      wr_reg(A_CLEAR, 32'h0F);
      chk_status("R6 partial clear", 8'hF0, 8'h0F);

      // R10: writes to status offsets ignored
      wr_reg(A_RAW, 32'h00);
      wr_reg(A_MASKED, 32'hFF);
      chk_reg("R10 dual kept", A_DUAL, 32'hFF);
      chk_reg("R10 enable kept", A_ENABLE, 32'h0F);
      chk_reg("R10 level kept", A_LEVEL, 32'h00);
      chk_status("R10 status kept", 8'hF0, 8'h0F);
      wr_reg(A_CLEAR, 32'hFF);
      set_pins('0);
      wr_reg(A_CLEAR, 32'hFF);
      chk_status("R6 all cleared", 8'h00, 8'h0F);

      // R7: edge and clear in the same cycle on pin 0
      set_pins(8'h01);
      chk_status("R7 setup", 8'h01, 8'h0F);
      @(negedge clk);
      pins = 8'h00; wr = 1'b1; addr = A_CLEAR; wdata = 32'h01;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
      chk_status("R7 edge wins", 8'h01, 8'h0F);
      wr_reg(A_CLEAR, 32'h01);
      chk_status("R7 later clear", 8'h00, 8'h0F);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule